// File: doc/BRIEF.md
# Carry-Save Multi-Operand Adder and Comparator

This block sums N signed operands of W bits in one pass. A per-operand subtract mask makes each operand either added or subtracted. Every subtraction is turned into addition first: the operand is bit-inverted, and a single one is injected into the least significant column. All operand bits, sign-extended to the result width, then form one carry-save tree. In each column, full adders are chosen greedily by a static arrival rank for each operand, so early operands are compressed while late ones are still in flight. Once at most two bits remain in every column, one carry-propagate adder resolves the sum.

The result width is W + ceil(log2 N) + 1, so the sum cannot overflow. Besides the sum, the block reports a negative flag and a zero flag. With two operands and the second one subtracted, these flags act as a magnitude comparator.

Input and output are valid/ready streams holding one result register. A transfer happens on a clock edge where valid and ready are both high. The input side is ready whenever the output register is empty or is being drained in the same cycle. While the output is valid and not taken, the output holds every field steady and refuses new input.

Top module: `csa_multi_adder`

## Requirements
- R1: On an accepted input, `sum` becomes the exact two's complement value, RW = W + ceil(log2 N) + 1 bits wide, of the sum over all operands. Operand i is negated when `sub_mask[i]` is 1 and added as is when it is 0. Operand i occupies `operands[W*i +: W]`.
- R2: `neg` is 1 exactly when the registered result is negative.
- R3: `zero` is 1 exactly when the registered result is zero, and it is never high together with `neg`.
- R4: With operand 0 added, operand 1 subtracted and all other operands zero, the flags compare the two values. `neg` set means operand 0 is less than operand 1, `zero` set means they are equal, and both clear means operand 0 is greater.
- R5: A result is presented on `out_valid` at the clock edge that accepts its input, with no added latency.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `sum`, `neg` and `zero` hold their values. Input offered during the stall is not taken until the output drains.
- R7: After reset `out_valid` is 0 and `in_ready` is 1. `out_valid` falls after an output transfer in which no new input is accepted.
- R8: Negating the most negative operand value is exact: the +1 term is not lost in the LSB column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take an operand set |
| operands | input | N*W | Packed signed operands, operand i at bits W*i upward |
| sub_mask | input | N | Bit i set: operand i is subtracted |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| sum | output | RW | Signed result |
| neg | output | 1 | Result is negative |
| zero | output | 1 | Result is zero |

## Verification
A three-operand, four-bit instance is swept over every operand value and every subtract mask. This exercises sign extension, the injected ones in the LSB column and the widest carry chains against an arithmetic sum, and separates errors in the sum bits from errors in the flags. The subset where operand 1 is subtracted and operand 2 is zero is also read as a comparison, which separates less, equal and greater. A directed stall holds `out_ready` low while new input is offered, which separates correct back-pressure from a result overwritten in the register.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // Result width for n operands of w bits, with sign and growth margin.
  function automatic int res_width(input int n, input int w);
    return w + $clog2(n) + 1;
  endfunction

  // Number of arrival rank slots carried by the rank parameter.
  localparam int MAX_OPS = 18;
  localparam int RANK_BITS = 4;
endpackage

// File: rtl/csa_operand_prep.sv
module csa_operand_prep #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int RW = 20
) (
  input  logic [N*W-1:0] operands,
  input  logic [N-1:0]   sub_mask,
  output logic [RW-1:0]  rows [N],
  output logic [N-1:0]   lsb_ones
);
  // Rewrite -X into ~X plus a one in the LSB column.
  for (genvar i = 0; i < N; i++) begin : g_row
    logic [W-1:0]  raw;
    logic [RW-1:0] ext;
    assign raw     = operands[W*i +: W];
    assign ext     = {{(RW-W){raw[W-1]}}, raw};
    assign rows[i] = ext ^ {RW{sub_mask[i]}};
  end
  assign lsb_ones = sub_mask;
endmodule

// File: rtl/csa_greedy_tree.sv
module csa_greedy_tree
  import csa_pkg::*;
#(
  parameter int N  = 8,
  parameter int RW = 20,
  parameter logic [MAX_OPS*RANK_BITS-1:0] RANKS = '0
) (
  input  logic [RW-1:0] rows [N],
  input  logic [N-1:0]  lsb_ones,
  output logic [RW-1:0] row_a,
  output logic [RW-1:0] row_b
);
  localparam int SLOTS = 4*N + 4;
  localparam int STEPS = N + 2;
  localparam int BIG   = 1 << 20;

  logic bv [RW][SLOTS];
  logic vv [RW][SLOTS];
  int   tm [RW][SLOTS];
  int   fill [RW];
  int   live [RW];
  int   p0, p1, p2, t0, t1, t2, found;
  logic fa_s, fa_c, xa, xb, xc;

  always_comb begin
    for (int c = 0; c < RW; c++) begin
      for (int s = 0; s < SLOTS; s++) begin
        bv[c][s] = 1'b0;
        vv[c][s] = 1'b0;
        tm[c][s] = 0;
      end
      for (int i = 0; i < N; i++) begin
        bv[c][i] = rows[i][c];
        vv[c][i] = 1'b1;
        tm[c][i] = int'(RANKS[RANK_BITS*i +: RANK_BITS]);
      end
      fill[c] = N;
      live[c] = N;
    end
    for (int i = 0; i < N; i++) begin
      bv[0][N+i] = lsb_ones[i];
      vv[0][N+i] = 1'b1;
      tm[0][N+i] = int'(RANKS[RANK_BITS*i +: RANK_BITS]);
    end
    fill[0] = 2*N;
    live[0] = 2*N;
    p0 = 0; p1 = 0; p2 = 0; t0 = 0; t1 = 0; t2 = 0;
    xa = 1'b0; xb = 1'b0; xc = 1'b0; fa_s = 1'b0; fa_c = 1'b0;
    row_a = '0;
    row_b = '0;
    found = 0;
    // Greedy compression: three earliest bits, lower slot wins ties.
    for (int c = 0; c < RW; c++) begin
      for (int k = 0; k < STEPS; k++) begin
        if (live[c] > 2) begin
          p0 = 0; p1 = 0; p2 = 0; t0 = BIG; t1 = BIG; t2 = BIG;
          for (int s = 0; s < SLOTS; s++) begin
            if (vv[c][s]) begin
              if (tm[c][s] < t0) begin
                p2 = p1; t2 = t1; p1 = p0; t1 = t0; p0 = s; t0 = tm[c][s];
              end else if (tm[c][s] < t1) begin
                p2 = p1; t2 = t1; p1 = s; t1 = tm[c][s];
              end else if (tm[c][s] < t2) begin
                p2 = s; t2 = tm[c][s];
              end
            end
          end
          xa = bv[c][p0];
          xb = bv[c][p1];
          xc = bv[c][p2];
          fa_s = xa ^ xb ^ xc;
          fa_c = (xa & xb) | (xa & xc) | (xb & xc);
          vv[c][p0] = 1'b0;
          vv[c][p1] = 1'b0;
          vv[c][p2] = 1'b0;
          bv[c][fill[c]] = fa_s;
          vv[c][fill[c]] = 1'b1;
          tm[c][fill[c]] = t2 + 1;
          fill[c] = fill[c] + 1;
          live[c] = live[c] - 2;
          if (c < RW-1) begin
            bv[c+1][fill[c+1]] = fa_c;
            vv[c+1][fill[c+1]] = 1'b1;
            tm[c+1][fill[c+1]] = t2 + 1;
            fill[c+1] = fill[c+1] + 1;
            live[c+1] = live[c+1] + 1;
          end
        end
      end
      found = 0;
      for (int s = 0; s < SLOTS; s++) begin
        if (vv[c][s]) begin
          if (found == 0) row_a[c] = bv[c][s];
          else            row_b[c] = bv[c][s];
          found = found + 1;
        end
      end
    end
  end
endmodule

// File: rtl/csa_final_add.sv
module csa_final_add #(
  parameter int RW = 20
) (
  input  logic [RW-1:0] row_a,
  input  logic [RW-1:0] row_b,
  output logic [RW-1:0] total,
  output logic          is_neg,
  output logic          is_zero
);
  assign total   = row_a + row_b;
  assign is_neg  = total[RW-1];
  assign is_zero = (total == '0);
endmodule

// File: rtl/csa_multi_adder.sv
module csa_multi_adder
  import csa_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter logic [MAX_OPS*RANK_BITS-1:0] RANKS = 72'h012345670123456701,
  localparam int RW = res_width(N, W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [N*W-1:0]  operands,
  input  logic [N-1:0]    sub_mask,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [RW-1:0]   sum,
  output logic            neg,
  output logic            zero
);
  logic [RW-1:0] rows [N];
  logic [N-1:0]  lsb_ones;
  logic [RW-1:0] row_a, row_b, total;
  logic          is_neg, is_zero, accept;

  csa_operand_prep #(.N(N), .W(W), .RW(RW)) u_prep (
    .operands(operands), .sub_mask(sub_mask), .rows(rows), .lsb_ones(lsb_ones)
  );

  csa_greedy_tree #(.N(N), .RW(RW), .RANKS(RANKS)) u_tree (
    .rows(rows), .lsb_ones(lsb_ones), .row_a(row_a), .row_b(row_b)
  );

  csa_final_add #(.RW(RW)) u_cpa (
    .row_a(row_a), .row_b(row_b), .total(total), .is_neg(is_neg), .is_zero(is_zero)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      neg       <= 1'b0;
      zero      <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      sum       <= total;
      neg       <= is_neg;
      zero      <= is_zero;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/csa_multi_adder_chk.sv
module csa_multi_adder_chk #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int RW = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [N*W-1:0]  operands,
  input logic [N-1:0]    sub_mask,
  input logic            out_valid,
  input logic            out_ready,
  input logic [RW-1:0]   sum,
  input logic            neg,
  input logic            zero
);
  logic signed [RW-1:0] ref_sum;
  always_comb begin
    ref_sum = '0;
    for (int i = 0; i < N; i++) begin
      if (sub_mask[i]) ref_sum = ref_sum - RW'($signed(operands[W*i +: W]));
      else             ref_sum = ref_sum + RW'($signed(operands[W*i +: W]));
    end
  end

  AST_SUM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> sum == $past(ref_sum)); // R1
  AST_NEG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> neg == $past(ref_sum[RW-1])); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(zero && neg)); // R3
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R5
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(sum) && $stable(neg) && $stable(zero)); // R6
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R7
endmodule

bind csa_multi_adder csa_multi_adder_chk #(.N(N), .W(W), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .operands(operands), .sub_mask(sub_mask), .out_valid(out_valid),
  .out_ready(out_ready), .sum(sum), .neg(neg), .zero(zero)
);

// File: tb/test_csa_multi_adder.sv
module test_csa_multi_adder;
  localparam int N  = 3;
  localparam int W  = 4;
  localparam int RW = W + $clog2(N) + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [N*W-1:0]  operands = '0;
  logic [N-1:0]    sub_mask = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [RW-1:0]   sum;
  logic            neg, zero;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  csa_multi_adder #(.N(N), .W(W), .RANKS(72'h201)) i_csa_multi_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .operands(operands), .sub_mask(sub_mask), .out_valid(out_valid),
    .out_ready(out_ready), .sum(sum), .neg(neg), .zero(zero)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_sum(input logic [N*W-1:0] ops, input logic [N-1:0] m);
    int e = 0;
    for (int i = 0; i < N; i++) begin
      int v = int'($signed(ops[W*i +: W]));
      e += m[i] ? -v : v;
    end
    return e;
  endfunction

  // One transfer: drive at a falling edge, sample at the next falling edge.
  task automatic run(input logic [N*W-1:0] ops, input logic [N-1:0] m);
    int e;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 drained", int'(out_valid), 0);
    operands = ops; sub_mask = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = expect_sum(ops, m);
    check(out_valid == 1'b1, "R5 valid", int'(out_valid), 1);
    check(int'($signed(sum)) == e, "R1 sum", int'($signed(sum)), e);
    check(neg == (e < 0), "R2 neg", int'(neg), int'(e < 0));
    check(zero == (e == 0), "R3 zero", int'(zero), int'(e == 0));
    if (m == 3'b010 && ops[W*2 +: W] == '0) begin
      int a = int'($signed(ops[W-1:0]));
      int b = int'($signed(ops[W*2-1:W]));
      int got = neg ? -1 : (zero ? 0 : 1);
      int want = (a < b) ? -1 : ((a == b) ? 0 : 1);
      check(got == want, "R4 compare", got, want);
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R7 reset ready", int'(in_ready), 1);

    // R8: every operand at the most negative value, all subtracted.
    run({3{4'b1000}}, 3'b111);
    check(int'($signed(sum)) == 24, "R8 negate min", int'($signed(sum)), 24);
    run({3{4'b0111}}, 3'b000);

    // Exhaustive sweep: R1 R2 R3 R4 R5 R7
    for (int m = 0; m < 8; m++)
      for (int v = 0; v < 4096; v++)
        run(12'(v), 3'(m));

    // R6: stall with a second input offered.
    @(negedge clk);
    out_ready = 1'b0;
    operands = {4'd1, 4'd2, 4'd3}; sub_mask = 3'b000; in_valid = 1'b1;
    @(negedge clk);
    operands = {4'd5, 4'd5, 4'd5};
    repeat (3) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R6 ready low", int'(in_ready), 0);
      check(out_valid == 1'b1, "R6 valid held", int'(out_valid), 1);
      check(int'($signed(sum)) == 6, "R6 sum held", int'($signed(sum)), 6);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    held = int'($signed(sum));
    check(held == 15, "R6 next after stall", held, 15);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 drain", int'(out_valid), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule